// File: doc/BRIEF.md
# Endpoint Test Command Controller

This block is a self-test function for a bus endpoint. It sits behind a 32-bit register window that the host drives. The host loads a 64-bit source address, a 64-bit destination address, a byte count, a checksum, an interrupt kind and an interrupt vector. It then writes a one-hot command word. Three data jobs run against a word-wide memory master port:

- **Read job:** fetches the source bytes and checks their CRC-32 against the checksum register.
- **Write job:** fills the destination with a deterministic pattern and publishes the CRC-32 of that pattern.
- **Copy job:** moves bytes from the source to the destination.

Three more command bits raise an interrupt directly. Every job ends by setting result bits in a status register and pulsing the selected interrupt output. The host acknowledges by writing the status register back.

The register bus returns read data one cycle after a read strobe. The memory port keeps at most one access outstanding. Read data comes back on `mem_rdata` qualified by `mem_rvalid`. Writes carry byte enables and need no response.

Top module: `xte_top`

## Requirements
- R1: Byte offset 0x00 reads the constant `MAGIC` (default 0x7E57C0DE). Writes to that offset leave the value unchanged.
- R2: The following registers read back what was last written:
  - source address low 0x0C and high 0x10
  - destination address low 0x14 and high 0x18
  - size 0x1C
  - checksum 0x20
  - interrupt kind 0x24
  - vector 0x28

  Memory addresses are `{high, low}` plus the running byte offset, so bits 63:32 of `mem_addr` equal the high register.
- R3: The command register at 0x04 uses these bits:
  - bit0: pulse the legacy interrupt
  - bit1: pulse the message interrupt
  - bit2: pulse the extended message interrupt
  - bit3: read job
  - bit4: write job
  - bit5: copy job

  If several bits are set, the lowest set bit wins. The register clears itself one cycle after it is written. A command written while a job is in progress is ignored.
- R4: The direct commands (bits 0 to 2) emit a one-cycle pulse on the matching output with `irq_vec` equal to the vector register. They also set status bit6.
- R5: A read job computes the CRC-32 over `size` bytes starting at the source address. If it equals the checksum register, status bit0 is set; otherwise status bit1 is set.
- R6: A write job stores word k (k counted from 0 at the destination) as `FILL_SEED ^ {~k[15:0], k[15:0]}`. In a partial last word it writes only the bytes below `size`. It then places the CRC-32 of the written bytes in the checksum register and sets status bit2.
- R7: A copy job makes the `size` destination bytes equal to the source bytes. It leaves the bytes past `size` unchanged and sets status bit4. (Status bit5 is the copy failure bit.)
- R8: The CRC-32 is the reflected form: polynomial 0xEDB88320, initial value 0xFFFFFFFF, bytes taken lowest address first, and no final inversion. The nine ASCII bytes "123456789" give 0x340BC6D9.
- R9: At the end of a data job, the interrupt kind register selects the output:
  - 0: legacy output
  - 1: message output
  - 2: extended message output

  Any of these kinds also sets status bit6. Any other kind value produces no pulse and leaves bit6 clear.
- R10: After reset, the status register is 0 and all interrupt outputs are low. A host write to the status register replaces its value. Bits set by the hardware in the same cycle take precedence.
- R11: If the source address of a read or copy job is not a multiple of 4, the job sets status bit7 and the job's fail bit. If the destination address of a write or copy job is not a multiple of 4, the job sets status bit8 and the job's fail bit. In either case the job makes no memory access and still raises the interrupt.
- R12: A job with size 0 makes no memory access.
  - A write job with size 0 publishes 0xFFFFFFFF.
  - A read job with size 0 passes only if the checksum register holds 0xFFFFFFFF.
  - A copy job with size 0 succeeds.
- R13: Flags register 0x2C stores only bit0 and reads back bit0 alone. It does not change any job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Memory byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Read data valid |
| irq_intx | output | 1 | Legacy interrupt pulse |
| irq_msi | output | 1 | Message interrupt pulse |
| irq_msix | output | 1 | Extended message interrupt pulse |
| irq_vec | output | VEC_W | Vector that goes with the pulse |

## Verification
A fixed known-answer string checks the CRC orientation on its own: a byte-order or polynomial slip shows up as a mismatch there even when every other test passes.

Random read, write and copy jobs use sizes 1 to 48 at random word offsets. Random read jobs take either the correct or a corrupted checksum. Together these separate partial-last-word handling, the byte-enable masks and the compare path.

Directed cases cover the following:
- zero-size jobs
- misaligned source and destination addresses
- an out-of-range interrupt kind
- a command issued during a long copy
- a multi-bit command word

Each of these isolates one control path: the status bits, the interrupt outputs and the count of memory requests show whether a job ran, stopped early or was ignored.

// File: rtl/xte_pkg.sv
package xte_pkg;
  localparam logic [5:0] OFS_MAGIC = 6'h00;
  localparam logic [5:0] OFS_CMD   = 6'h04;
  localparam logic [5:0] OFS_STAT  = 6'h08;
  localparam logic [5:0] OFS_SRCL  = 6'h0C;
  localparam logic [5:0] OFS_SRCH  = 6'h10;
  localparam logic [5:0] OFS_DSTL  = 6'h14;
  localparam logic [5:0] OFS_DSTH  = 6'h18;
  localparam logic [5:0] OFS_SIZE  = 6'h1C;
  localparam logic [5:0] OFS_CSUM  = 6'h20;
  localparam logic [5:0] OFS_KIND  = 6'h24;
  localparam logic [5:0] OFS_VEC   = 6'h28;
  localparam logic [5:0] OFS_FLAG  = 6'h2C;

  localparam int CMD_W  = 6;
  localparam int STAT_W = 9;
  localparam int SB_RD_OK = 0, SB_RD_BAD = 1, SB_WR_OK = 2, SB_WR_BAD = 3;
  localparam int SB_CP_OK = 4, SB_CP_BAD = 5, SB_IRQ = 6, SB_SRC_BAD = 7, SB_DST_BAD = 8;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {OP_NONE, OP_INTX, OP_MSI, OP_MSIX, OP_READ, OP_WRITE, OP_COPY} op_e;

  function automatic logic [3:0] lane_mask(input logic [2:0] nb);
    case (nb)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/xte_crc_unit.sv
module xte_crc_unit
  import xte_pkg::*;
(
  input  logic [31:0] crc_in,
  input  logic [31:0] word,
  input  logic [2:0]  nbytes,
  output logic [31:0] crc_out
);
  always_comb begin
    logic [31:0] c;
    c = crc_in;
    for (int b = 0; b < 4; b++) begin
      if (b < int'(nbytes)) begin
        c = c ^ {24'h0, word[8*b +: 8]};
        for (int i = 0; i < 8; i++)
          c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
      end
    end
    crc_out = c;
  end
endmodule

// File: rtl/xte_irq_gen.sv
module xte_irq_gen #(
  parameter int VEC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [1:0]       kind,
  input  logic [VEC_W-1:0] vec_in,
  output logic             raised,
  output logic             irq_intx,
  output logic             irq_msi,
  output logic             irq_msix,
  output logic [VEC_W-1:0] irq_vec
);
  assign raised = fire && (kind != 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_intx <= 1'b0;
      irq_msi  <= 1'b0;
      irq_msix <= 1'b0;
      irq_vec  <= '0;
    end else begin
      irq_intx <= fire && (kind == 2'd0);
      irq_msi  <= fire && (kind == 2'd1);
      irq_msix <= fire && (kind == 2'd2);
      if (raised) irq_vec <= vec_in;
    end
  end

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0({irq_intx, irq_msi, irq_msix})); // R4
  AST_BAD_KIND_SILENT: assert property (@(posedge clk) disable iff (rst) (fire && kind == 2'd3) |=> !(irq_intx || irq_msi || irq_msix)); // R9
endmodule

// File: rtl/xte_seq.sv
module xte_seq
  import xte_pkg::*;
#(
  parameter int          AW        = 64,
  parameter int          VEC_W     = 11,
  parameter logic [31:0] FILL_SEED = 32'hC3A5_0F96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  input  logic [31:0]       cfg_size,
  input  logic [31:0]       cfg_csum,
  input  logic [31:0]       cfg_kind,
  input  logic [VEC_W-1:0]  cfg_vec,
  output logic              busy,
  output logic              fin,
  output logic [STAT_W-1:0] fin_bits,
  output logic [1:0]        fin_kind,
  output logic [VEC_W-1:0]  fin_vec,
  output logic              fin_csum_wr,
  output logic [31:0]       fin_csum,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rvalid
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_ISSUE, S_WAIT, S_STEP, S_CHECK, S_FINISH} st_e;

  st_e               state;
  op_e               op_q;
  logic [AW-1:0]     src_q, dst_q;
  logic [31:0]       off_q, rem_q, want_q, crc_q;
  logic [1:0]        kind_q;
  logic [VEC_W-1:0]  vec_q;
  logic [STAT_W-1:0] res_q;

  logic [2:0]  nb;
  logic [15:0] widx;
  logic [31:0] pattern, crc_data, crc_nx;

  assign nb       = (rem_q >= 32'd4) ? 3'd4 : rem_q[2:0];
  assign widx     = off_q[17:2];
  assign pattern  = FILL_SEED ^ {~widx, widx};
  assign crc_data = (op_q == OP_WRITE) ? pattern : mem_rdata;

  xte_crc_unit u_crc (.crc_in(crc_q), .word(crc_data), .nbytes(nb), .crc_out(crc_nx));

  assign busy        = (state != S_IDLE);
  assign fin         = (state == S_FINISH);
  assign fin_bits    = res_q;
  assign fin_kind    = kind_q;
  assign fin_vec     = vec_q;
  assign fin_csum_wr = fin && (op_q == OP_WRITE) && (res_q[SB_WR_OK]);
  assign fin_csum    = crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;     op_q <= OP_NONE;
      src_q <= '0;  dst_q <= '0;  off_q <= '0;  rem_q <= '0;
      want_q <= '0; crc_q <= CRC_INIT; kind_q <= 2'd3; vec_q <= '0; res_q <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_be <= '0; mem_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          src_q  <= cfg_src;  dst_q <= cfg_dst;  rem_q <= cfg_size;  off_q <= '0;
          want_q <= cfg_csum; crc_q <= CRC_INIT; vec_q <= cfg_vec;   res_q <= '0;
          kind_q <= (cfg_kind > 32'd2) ? 2'd3 : cfg_kind[1:0];
          state  <= S_START;
          if (cmd[0])      begin op_q <= OP_INTX;  kind_q <= 2'd0; state <= S_FINISH; end
          else if (cmd[1]) begin op_q <= OP_MSI;   kind_q <= 2'd1; state <= S_FINISH; end
          else if (cmd[2]) begin op_q <= OP_MSIX;  kind_q <= 2'd2; state <= S_FINISH; end
          else if (cmd[3]) op_q <= OP_READ;
          else if (cmd[4]) op_q <= OP_WRITE;
          else             op_q <= OP_COPY;
        end
        S_START: begin
          if (((op_q != OP_WRITE) && (src_q[1:0] != 2'b00)) ||
              ((op_q != OP_READ) && (dst_q[1:0] != 2'b00))) begin
            res_q[SB_SRC_BAD] <= (op_q != OP_WRITE) && (src_q[1:0] != 2'b00);
            res_q[SB_DST_BAD] <= (op_q != OP_READ) && (dst_q[1:0] != 2'b00);
            res_q[SB_RD_BAD]  <= (op_q == OP_READ);
            res_q[SB_WR_BAD]  <= (op_q == OP_WRITE);
            res_q[SB_CP_BAD]  <= (op_q == OP_COPY);
            state <= S_FINISH;
          end else if (rem_q == '0) begin
            state <= S_CHECK;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          mem_req <= 1'b1;
          if (op_q == OP_WRITE) begin
            mem_we    <= 1'b1;
            mem_addr  <= dst_q + AW'(off_q);
            mem_wdata <= pattern;
            mem_be    <= lane_mask(nb);
            crc_q     <= crc_nx;
            state     <= S_STEP;
          end else begin
            mem_we   <= 1'b0;
            mem_addr <= src_q + AW'(off_q);
            mem_be   <= 4'hF;
            state    <= S_WAIT;
          end
        end
        S_WAIT: begin
          mem_req <= 1'b0;
          if (mem_rvalid) begin
            if (op_q == OP_READ) begin
              crc_q <= crc_nx;
            end else begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= dst_q + AW'(off_q);
              mem_wdata <= mem_rdata;
              mem_be    <= lane_mask(nb);
            end
            state <= S_STEP;
          end
        end
        S_STEP: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          off_q   <= off_q + 32'd4;
          rem_q   <= rem_q - 32'(nb);
          state   <= (rem_q <= 32'd4) ? S_CHECK : S_ISSUE;
        end
        S_CHECK: begin
          res_q[SB_RD_OK]  <= (op_q == OP_READ) && (crc_q == want_q);
          res_q[SB_RD_BAD] <= (op_q == OP_READ) && (crc_q != want_q);
          res_q[SB_WR_OK]  <= (op_q == OP_WRITE);
          res_q[SB_CP_OK]  <= (op_q == OP_COPY);
          state <= S_FINISH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (rst) mem_req |-> (mem_addr[1:0] == 2'b00)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (state == S_IDLE) |-> !mem_req); // R3
endmodule

// File: rtl/xte_top.sv
module xte_top
  import xte_pkg::*;
#(
  parameter logic [31:0] MAGIC     = 32'h7E57_C0DE,
  parameter int          VEC_W     = 11,
  parameter logic [31:0] FILL_SEED = 32'hC3A5_0F96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [5:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_rvalid,
  output logic             irq_intx,
  output logic             irq_msi,
  output logic             irq_msix,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int AW = 64;

  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] stat_q;
  logic [31:0]       srcl_q, srch_q, dstl_q, dsth_q, size_q, csum_q, kind_q, vec_q;
  logic              flag_q;

  logic              busy, fin, fin_csum_wr, raised;
  logic [STAT_W-1:0] fin_bits, set_bits;
  logic [1:0]        fin_kind;
  logic [VEC_W-1:0]  fin_vec;
  logic [31:0]       fin_csum;
  logic [5:0]        wofs;

  assign wofs = {reg_addr[5:2], 2'b00};

  xte_seq #(.AW(AW), .VEC_W(VEC_W), .FILL_SEED(FILL_SEED)) u_seq (
    .clk(clk), .rst(rst), .start(cmd_q != '0), .cmd(cmd_q),
    .cfg_src({srch_q, srcl_q}), .cfg_dst({dsth_q, dstl_q}), .cfg_size(size_q),
    .cfg_csum(csum_q), .cfg_kind(kind_q), .cfg_vec(vec_q[VEC_W-1:0]),
    .busy(busy), .fin(fin), .fin_bits(fin_bits), .fin_kind(fin_kind), .fin_vec(fin_vec),
    .fin_csum_wr(fin_csum_wr), .fin_csum(fin_csum),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  xte_irq_gen #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst(rst), .fire(fin), .kind(fin_kind), .vec_in(fin_vec), .raised(raised),
    .irq_intx(irq_intx), .irq_msi(irq_msi), .irq_msix(irq_msix), .irq_vec(irq_vec)
  );

  always_comb begin
    set_bits = fin ? fin_bits : '0;
    set_bits[SB_IRQ] = raised;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; stat_q <= '0; srcl_q <= '0; srch_q <= '0; dstl_q <= '0; dsth_q <= '0;
      size_q <= '0; csum_q <= '0; kind_q <= '0; vec_q <= '0; flag_q <= 1'b0; reg_rdata <= '0;
    end else begin
      if (cmd_q != '0) cmd_q <= '0;
      else if (reg_wr && wofs == OFS_CMD && !busy) cmd_q <= reg_wdata[CMD_W-1:0];

      stat_q <= ((reg_wr && wofs == OFS_STAT) ? reg_wdata[STAT_W-1:0] : stat_q) | set_bits;

      if (reg_wr) begin
        case (wofs)
          OFS_SRCL: srcl_q <= reg_wdata;
          OFS_SRCH: srch_q <= reg_wdata;
          OFS_DSTL: dstl_q <= reg_wdata;
          OFS_DSTH: dsth_q <= reg_wdata;
          OFS_SIZE: size_q <= reg_wdata;
          OFS_KIND: kind_q <= reg_wdata;
          OFS_VEC:  vec_q  <= reg_wdata;
          OFS_FLAG: flag_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (fin_csum_wr)                      csum_q <= fin_csum;
      else if (reg_wr && wofs == OFS_CSUM)  csum_q <= reg_wdata;

      if (reg_rd) begin
        case (wofs)
          OFS_MAGIC: reg_rdata <= MAGIC;
          OFS_CMD:   reg_rdata <= 32'(cmd_q);
          OFS_STAT:  reg_rdata <= 32'(stat_q);
          OFS_SRCL:  reg_rdata <= srcl_q;
          OFS_SRCH:  reg_rdata <= srch_q;
          OFS_DSTL:  reg_rdata <= dstl_q;
          OFS_DSTH:  reg_rdata <= dsth_q;
          OFS_SIZE:  reg_rdata <= size_q;
          OFS_CSUM:  reg_rdata <= csum_q;
          OFS_KIND:  reg_rdata <= kind_q;
          OFS_VEC:   reg_rdata <= vec_q;
          OFS_FLAG:  reg_rdata <= {31'h0, flag_q};
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) (cmd_q != '0) |=> (cmd_q == '0)); // R3
  AST_PULSE_MARKS_STATUS: assert property (@(posedge clk) disable iff (rst) (irq_intx || irq_msi || irq_msix) |-> stat_q[SB_IRQ]); // R4
endmodule

// File: tb/xte_top_tb.sv
module xte_top_tb;
  localparam int          VW   = 11;
  localparam logic [31:0] SEED = 32'hC3A5_0F96;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_rvalid = 1'b0;
  logic [63:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        irq_intx, irq_msi, irq_msix;
  logic [VW-1:0] irq_vec;

  xte_top #(.VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .irq_intx(irq_intx), .irq_msi(irq_msi), .irq_msix(irq_msix),
    .irq_vec(irq_vec)
  );

  logic [31:0] mem [0:1023];
  int n_chk = 0, n_err = 0, n_intx = 0, n_msi = 0, n_msix = 0, n_acc = 0;
  logic [VW-1:0] last_vec = '0;
  logic [31:0]   last_hi = '0;
  logic [31:0]   addr_hi = 32'h0000_0001;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata  <= mem[mem_addr[11:2]];
        mem_rvalid <= 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (irq_intx) n_intx++;
    if (irq_msi)  n_msi++;
    if (irq_msix) n_msix++;
    if (irq_intx || irq_msi || irq_msix) last_vec = irq_vec;
    if (mem_req) begin n_acc++; last_hi = mem_addr[63:32]; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_done(input logic [8:0] mask, output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 600; i++) begin
      rd(6'h08, st);
      if ((st[8:0] & mask) != 0) break;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] gb(input int a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] crc_of(input int a, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, gb(a + i)};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] fill_byte(input int k);
    logic [15:0] w = 16'(k / 4);
    logic [31:0] v = SEED ^ {~w, w};
    return v[8*(k % 4) +: 8];
  endfunction

  function automatic logic [31:0] fill_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, fill_byte(i)};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic run_op(input logic [5:0] cmd, input int src, input int dst, input int size,
                        input logic [31:0] csum, input logic [31:0] kind, output logic [31:0] st);
    wr(6'h0C, src); wr(6'h10, addr_hi); wr(6'h14, dst); wr(6'h18, addr_hi);
    wr(6'h1C, size); wr(6'h20, csum); wr(6'h24, kind); wr(6'h28, 32'd5);
    wr(6'h08, 32'd0); wr(6'h04, {26'h0, cmd});
    wait_done(9'h03F, st);
  endtask

  logic [31:0] st, v, c;
  logic [7:0]  tail [0:3];
  int          a0, i0, i1, i2;

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    rd(6'h08, st); chk("R10 status after reset", st, 0);
    chk("R10 irq outputs after reset", {irq_intx, irq_msi, irq_msix}, 0);

    // R1 magic
    rd(6'h00, v); chk("R1 magic", v, 32'h7E57C0DE);
    wr(6'h00, 32'h0); rd(6'h00, v); chk("R1 magic after write", v, 32'h7E57C0DE);

    // R2 readback, R13 flags
    wr(6'h0C, 32'h1111_2220); rd(6'h0C, v); chk("R2 src low", v, 32'h1111_2220);
    wr(6'h18, 32'hABCD_0001); rd(6'h18, v); chk("R2 dst high", v, 32'hABCD_0001);
    wr(6'h28, 32'h0000_0155); rd(6'h28, v); chk("R2 vector", v, 32'h155);
    wr(6'h2C, 32'hFFFF_FFFF); rd(6'h2C, v); chk("R13 flags bit0 only", v, 1);

    // R4 direct interrupt commands
    wr(6'h28, 32'd9); wr(6'h08, 0); i0 = n_intx; wr(6'h04, 32'h1); wait_done(9'h040, st);
    chk("R4 intx pulse", n_intx - i0, 1); chk("R4 vector", last_vec, 9); chk("R4 status", st, 32'h40);
    wr(6'h08, 0); i1 = n_msi; wr(6'h04, 32'h2); wait_done(9'h040, st);
    chk("R4 msi pulse", n_msi - i1, 1);
    wr(6'h08, 0); i2 = n_msix; wr(6'h04, 32'h4); wait_done(9'h040, st);
    chk("R4 msix pulse", n_msix - i2, 1);
    // R3 lowest set bit wins
    wr(6'h08, 0); i1 = n_msi; i2 = n_msix; wr(6'h04, 32'h6); wait_done(9'h040, st);
    chk("R3 priority msi", n_msi - i1, 1); chk("R3 priority no msix", n_msix - i2, 0);
    rd(6'h04, v); chk("R3 cmd self-clear", v, 0);

    // R8 known answer, R5 addressing high half
    addr_hi = 32'h0000_0001;
    for (int i = 0; i < 9; i++) mem[(256 + i) / 4][8*((256 + i) % 4) +: 8] = 8'h31 + 8'(i);
    run_op(6'h08, 256, 32'h400, 9, 32'h340BC6D9, 1, st);
    chk("R8 crc known answer", st, 32'h41);
    chk("R2 address high half", last_hi, 32'h1);
    run_op(6'h08, 256, 32'h400, 9, 32'h340BC6D8, 1, st);
    chk("R5 wrong checksum fails", st, 32'h42);

    // R9 kind selection
    i0 = n_intx; run_op(6'h08, 256, 32'h400, 9, 32'h340BC6D9, 0, st);
    chk("R9 kind 0 legacy", n_intx - i0, 1);
    i2 = n_msix; run_op(6'h10, 0, 32'h400, 8, 0, 2, st);
    chk("R9 kind 2 msix", n_msix - i2, 1);
    i0 = n_intx + n_msi + n_msix; run_op(6'h10, 0, 32'h400, 8, 0, 3, st);
    chk("R9 bad kind status", st, 32'h04);
    chk("R9 bad kind no pulse", n_intx + n_msi + n_msix - i0, 0);

    // R10 status writeback
    wr(6'h08, 32'h004); rd(6'h08, v); chk("R10 status write replaces", v, 32'h004);

    // R11 misaligned
    i0 = n_acc; run_op(6'h08, 258, 32'h400, 8, 0, 1, st);
    chk("R11 bad src read", st, 32'hC2); chk("R11 no access", n_acc - i0, 0);
    i0 = n_acc; run_op(6'h20, 256, 32'h401, 8, 0, 1, st);
    chk("R11 bad dst copy", st, 32'h160); chk("R11 no access copy", n_acc - i0, 0);

    // R12 zero size
    i0 = n_acc; run_op(6'h10, 0, 32'h400, 0, 32'h1234, 1, st);
    chk("R12 zero write status", st, 32'h44);
    rd(6'h20, v); chk("R12 zero write crc", v, 32'hFFFF_FFFF);
    run_op(6'h08, 0, 32'h400, 0, 32'hFFFF_FFFF, 1, st);
    chk("R12 zero read status", st, 32'h41); chk("R12 zero no access", n_acc - i0, 0);

    // R3 command during busy ignored
    wr(6'h0C, 0); wr(6'h14, 32'h600); wr(6'h1C, 64); wr(6'h20, 32'hDEADBEEF);
    wr(6'h24, 1); wr(6'h08, 0); wr(6'h04, 32'h20); wr(6'h04, 32'h10);
    wait_done(9'h03F, st);
    chk("R3 busy ignore status", st, 32'h50);
    rd(6'h20, v); chk("R3 busy ignore checksum", v, 32'hDEADBEEF);

    // random jobs R5 R6 R7
    for (int it = 0; it < 24; it++) begin
      int op, sz, sa, da;
      op = $urandom % 3; sz = 1 + $urandom % 48;
      sa = 4 * ($urandom % 200); da = 32'h400 + 4 * ($urandom % 200);
      addr_hi = $urandom;
      for (int i = 0; i < 52; i++) mem[(sa + i) / 4][8*((sa + i) % 4) +: 8] = 8'($urandom);
      for (int i = 0; i < 4; i++) tail[i] = gb(da + sz + i);
      if (op == 0) begin
        logic good;
        good = 1'($urandom);
        c = crc_of(sa, sz);
        run_op(6'h08, sa, da, sz, good ? c : (c ^ 32'h80), 1, st);
        chk("R5 random read", st, good ? 32'h41 : 32'h42);
      end else if (op == 1) begin
        run_op(6'h10, sa, da, sz, 0, 1, st);
        chk("R6 random write status", st, 32'h44);
        rd(6'h20, v); chk("R6 published crc", v, fill_crc(sz));
        a0 = 0;
        for (int i = 0; i < sz; i++) if (gb(da + i) !== fill_byte(i)) a0++;
        chk("R6 fill bytes", a0, 0);
        a0 = 0;
        for (int i = sz; i < ((sz + 3) / 4) * 4; i++) if (gb(da + i) !== tail[i - sz]) a0++;
        chk("R6 tail untouched", a0, 0);
      end else begin
        run_op(6'h20, sa, da, sz, 0, 1, st);
        chk("R7 random copy status", st, 32'h50);
        chk("R2 random high half", last_hi, addr_hi);
        a0 = 0;
        for (int i = 0; i < sz; i++) if (gb(da + i) !== gb(sa + i)) a0++;
        chk("R7 copied bytes", a0, 0);
        a0 = 0;
        for (int i = sz; i < ((sz + 3) / 4) * 4; i++) if (gb(da + i) !== tail[i - sz]) a0++;
        chk("R7 tail untouched", a0, 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule